// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and turns the most urgent one into a call request that carries a fixed vector address. It has six sources: two external pins, a comparator output, two timer overflows and the end-of-conversion event of an analog-to-digital converter. Each source gives a one-cycle event pulse, and the block latches that pulse as a request flag. Two 8-bit control registers hold the flags, one enable bit per source and a master enable. The core reads and writes these registers through a simple register port, so firmware can raise a request, cancel one, or mask one.

Pending requests are examined only when the phase strobe is high. At such a cycle the block issues a one-cycle call pulse and holds the vector until the core acknowledges it. A source must meet four conditions at that strobe: its flag is set, its enable is 1, the master enable is 1, and the core reports room on its return stack. When the core acknowledges, the block clears the flag of the granted source and the master enable. A return-from-interrupt pulse sets the master enable again. A plain return gives no pulse and leaves the enable cleared, so further requests stay pending.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, both control registers read 0x00 and no call request is issued.
- R2: Control register A sits at address 0x0B. Its bit 0 is the master enable. Bits 1, 2 and 3 are the enables of sources 0, 1 and 2 (pin 0, pin 1, comparator). Bits 4, 5 and 6 are the flags of the same three sources. Bit 7 reads 0 and must be written 0. Control register B sits at address 0x1E. Its bits 0, 1 and 2 are the enables of sources 3, 4 and 5 (timer 0, timer 1, converter). Bits 4, 5 and 6 are the matching flags. Bits 3 and 7 read 0 and must be written 0. Read data is registered and appears one cycle after the address. Any other address reads 0x00.
- R3: An event pulse on a source sets its flag on the next clock edge. If a register write stores 0 into the same flag in the same cycle, the event still sets the flag.
- R4: A register write can set a flag, which raises a request, or clear a flag, which cancels a pending request.
- R5: A source is eligible only when its flag, its enable and the master enable are all 1 and stack_full_i is 0.
- R6: Requests are examined only in a cycle where phase_stb_i is high. A request that becomes pending between two strobes is serviced at the next strobe. call_req_o is high for exactly the one cycle after that strobe.
- R7: Priority runs from source 0 (highest) to source 5 (lowest). The vector for source k is 0x04·(k+1), which gives 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18.
- R8: When call_ack_i is high while a call is outstanding, the granted source's flag and the master enable clear on that edge. The other flags stay set.
- R9: While a call waits for its acknowledge, no further call is issued.
- R10: A reti_i pulse sets the master enable. A return without that pulse leaves the master enable cleared.
- R11: When software sets the master enable and a source enable while that source's flag is pending, the source is serviced at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_stb_i | input | 1 | Phase strobe: cycles in which requests are examined |
| evt_i | input | 6 | Event pulses, bit k = source k |
| stack_full_i | input | 1 | Core return stack is full |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| call_req_o | output | 1 | One-cycle call request |
| call_vec_o | output | 8 | Vector of the outstanding call |
| call_ack_i | input | 1 | Core accepts the outstanding call |
| reti_i | input | 1 | Return-from-interrupt pulse |

## Verification
The bench runs a behavioural model next to the block and compares call_req_o, call_vec_o and reg_rdata_o on every clock. It also makes directed checks. The first pattern sets all six sources at once and then drains them with a mix of reti pulses and plain returns. This shows that priority order, vector values and master-enable handling are separate behaviours. Later patterns withhold one eligibility condition at a time (source enable, master enable, stack room, strobe). They also place an event pulse in the same cycle as a software clear, and set and cancel flags by write. Each of these patterns fails on a different single fault in the gating or in the order in which flag updates are applied.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Register selected by the address decoder
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2
  } reg_sel_e;

  // Bit positions inside a control register
  localparam int GIE_BIT  = 0;
  localparam int FLAG_LSB = 4;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter logic [AW-1:0] ADDR_A = 8'h0B,
  parameter logic [AW-1:0] ADDR_B = 8'h1E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N_SRC-1:0] clr_mask_i,
  input  logic             clr_gie_i,
  input  logic             set_gie_i,
  input  logic             stack_full_i,
  output logic [DW-1:0]    rdata_o,
  output logic [N_SRC-1:0] elig_o
);
  localparam int HALF = N_SRC / 2;

  logic [N_SRC-1:0] flg_q, flg_n, en_q, en_n;
  logic             gie_q, gie_n;
  reg_sel_e         sel;
  logic [DW-1:0]    view_a, view_b, rd_n;

  always_comb begin
    if (addr_i == ADDR_A)      sel = SEL_A;
    else if (addr_i == ADDR_B) sel = SEL_B;
    else                       sel = SEL_NONE;
  end

  // Update order: software write, then reti, then acknowledge, then events
  always_comb begin
    flg_n = flg_q;
    en_n  = en_q;
    gie_n = gie_q;
    if (we_i && sel == SEL_A) begin
      gie_n                = wdata_i[GIE_BIT];
      en_n[0 +: HALF]      = wdata_i[1 +: HALF];
      flg_n[0 +: HALF]     = wdata_i[FLAG_LSB +: HALF];
    end else if (we_i && sel == SEL_B) begin
      en_n[HALF +: HALF]   = wdata_i[0 +: HALF];
      flg_n[HALF +: HALF]  = wdata_i[FLAG_LSB +: HALF];
    end
    if (set_gie_i) gie_n = 1'b1;
    if (clr_gie_i) gie_n = 1'b0;
    flg_n = (flg_n & ~clr_mask_i) | evt_i;
  end

  always_comb begin
    view_a                   = '0;
    view_a[GIE_BIT]          = gie_q;
    view_a[1 +: HALF]        = en_q[0 +: HALF];
    view_a[FLAG_LSB +: HALF] = flg_q[0 +: HALF];
    view_b                   = '0;
    view_b[0 +: HALF]        = en_q[HALF +: HALF];
    view_b[FLAG_LSB +: HALF] = flg_q[HALF +: HALF];
    case (sel)
      SEL_A:   rd_n = view_a;
      SEL_B:   rd_n = view_b;
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q   <= '0;
      en_q    <= '0;
      gie_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      flg_q   <= flg_n;
      en_q    <= en_n;
      gie_q   <= gie_n;
      rdata_o <= rd_n;
    end
  end

  assign elig_o = flg_q & en_q & {N_SRC{gie_q & ~stack_full_i}};

  // R3: every event pulse leaves its flag set
  assert_evt_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((flg_q & $past(evt_i)) == $past(evt_i)));

  // R8: acknowledge clears the master enable, whatever else happens
  assert_ack_clears_gie_R8: assert property (@(posedge clk) disable iff (rst)
    clr_gie_i |=> !gie_q);

  // R10: reti sets the master enable unless an acknowledge collides
  assert_reti_sets_gie_R10: assert property (@(posedge clk) disable iff (rst)
    (set_gie_i && !clr_gie_i) |=> gie_q);

  // R2: reserved bits are written as zero
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (we_i && sel != SEL_NONE) |->
      (!wdata_i[DW-1] && (sel != SEL_B || !wdata_i[FLAG_LSB-1])));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 6,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] grant_o,
  output logic [IW-1:0]    idx_o,
  output logic             any_o
);
  // Lowest index wins: scan from the bottom of the priority list upward
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_call_seq.sv
module irq_call_seq #(
  parameter int N_SRC    = 6,
  parameter int VW       = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  localparam int IW      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_i,
  input  logic             stack_full_i,
  input  logic [N_SRC-1:0] grant_i,
  input  logic [IW-1:0]    idx_i,
  input  logic             any_i,
  input  logic             ack_i,
  output logic             call_req_o,
  output logic [VW-1:0]    call_vec_o,
  output logic [N_SRC-1:0] clr_mask_o,
  output logic             clr_gie_o
);
  logic             pend_q;
  logic [N_SRC-1:0] gnt_q;
  logic             ack_fire;
  logic             launch;

  assign ack_fire   = pend_q & ack_i;
  assign launch     = stb_i & ~pend_q & any_i;
  assign clr_mask_o = ack_fire ? gnt_q : '0;
  assign clr_gie_o  = ack_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      gnt_q      <= '0;
      call_req_o <= 1'b0;
      call_vec_o <= '0;
    end else begin
      call_req_o <= 1'b0;
      if (ack_fire) pend_q <= 1'b0;
      if (launch) begin
        pend_q     <= 1'b1;
        call_req_o <= 1'b1;
        gnt_q      <= grant_i;
        call_vec_o <= VW'(VEC_BASE + int'(idx_i) * VEC_STEP);
      end
    end
  end

  // R6: a call follows a strobe by exactly one cycle
  assert_req_after_stb_R6: assert property (@(posedge clk) disable iff (rst)
    call_req_o |-> $past(stb_i));

  // R6: the call request is a single-cycle pulse
  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    call_req_o |=> !call_req_o);

  // R5: no call is launched while the return stack is full
  assert_no_call_full_R5: assert property (@(posedge clk) disable iff (rst)
    call_req_o |-> !$past(stack_full_i));

  // R9: an outstanding call blocks new calls until acknowledged
  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !ack_i) |=> !call_req_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC    = 6,
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int VW       = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  parameter logic [AW-1:0] ADDR_A = 8'h0B,
  parameter logic [AW-1:0] ADDR_B = 8'h1E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_stb_i,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             stack_full_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             call_req_o,
  output logic [VW-1:0]    call_vec_o,
  input  logic             call_ack_i,
  input  logic             reti_i
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] elig, grant, clr_mask;
  logic [IW-1:0]    idx;
  logic             any, clr_gie;

  irq_flag_bank #(
    .N_SRC(N_SRC), .AW(AW), .DW(DW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
  ) u_bank (
    .clk(clk), .rst(rst), .evt_i(evt_i), .we_i(reg_we_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .clr_mask_i(clr_mask),
    .clr_gie_i(clr_gie), .set_gie_i(reti_i), .stack_full_i(stack_full_i),
    .rdata_o(reg_rdata_o), .elig_o(elig)
  );

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .req_i(elig), .grant_o(grant), .idx_o(idx), .any_o(any)
  );

  irq_call_seq #(
    .N_SRC(N_SRC), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_seq (
    .clk(clk), .rst(rst), .stb_i(phase_stb_i), .stack_full_i(stack_full_i),
    .grant_i(grant), .idx_i(idx), .any_i(any), .ack_i(call_ack_i),
    .call_req_o(call_req_o), .call_vec_o(call_vec_o),
    .clr_mask_o(clr_mask), .clr_gie_o(clr_gie)
  );
endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stb = 1'b0;
  logic [5:0] evt = '0;
  logic       sfull = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       creq;
  logic [7:0] cvec;
  logic       ack = 1'b0;
  logic       reti = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst(rst), .phase_stb_i(stb), .evt_i(evt), .stack_full_i(sfull),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .call_req_o(creq), .call_vec_o(cvec), .call_ack_i(ack), .reti_i(reti)
  );

  // ---------------- behavioural reference model ----------------
  bit [5:0] m_flag, m_en;
  bit       m_gie, m_pend, m_req;
  int       m_idx, m_vec, m_rd;

  function automatic int view(int a);
    if (a == 8'h0B) return m_gie | (m_en[2:0] << 1) | (m_flag[2:0] << 4);
    if (a == 8'h1E) return m_en[5:3] | (m_flag[5:3] << 4);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_flag = '0; m_en = '0; m_gie = 0; m_pend = 0; m_req = 0;
      m_idx = 0; m_vec = 0; m_rd = 0;
    end else begin
      bit [5:0] elig;
      bit       acked;
      int       pick;
      m_rd  = view(addr);
      elig  = m_flag & m_en & {6{m_gie && !sfull}};
      acked = m_pend && ack;
      pick  = -1;
      for (int k = 5; k >= 0; k--) if (elig[k]) pick = k;
      m_req = 0;
      if (acked) m_pend = 0;
      if (we && addr == 8'h0B) begin
        m_gie = wdata[0];
        for (int k = 0; k < 3; k++) begin
          m_en[k] = wdata[1+k]; m_flag[k] = wdata[4+k];
        end
      end else if (we && addr == 8'h1E) begin
        for (int k = 0; k < 3; k++) begin
          m_en[3+k] = wdata[k]; m_flag[3+k] = wdata[4+k];
        end
      end
      if (reti) m_gie = 1;
      if (acked) begin m_gie = 0; m_flag[m_idx] = 0; end
      m_flag = m_flag | evt;
      if (stb && !(m_pend || acked) && pick >= 0) begin
        m_pend = 1; m_req = 1; m_idx = pick; m_vec = 4 * (pick + 1);
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) if (!rst && !done) begin
    chk(creq == m_req, "R6 model call_req", int'(creq), int'(m_req));
    if (m_req) chk(int'(cvec) == m_vec, "R7 model vector", int'(cvec), m_vec);
    chk(int'(rdata) == m_rd, "R2 model rdata", int'(rdata), m_rd);
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1; addr = a; wdata = d; cyc(); we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    addr = a; cyc();
    chk(int'(rdata) == exp, tag, int'(rdata), exp);
  endtask

  task automatic strobe(input int exp_vec, input string tag);
    stb = 1; cyc(); stb = 0;
    if (exp_vec < 0) chk(creq == 1'b0, tag, int'(creq), 0);
    else begin
      chk(creq == 1'b1, tag, int'(creq), 1);
      chk(int'(cvec) == exp_vec, tag, int'(cvec), exp_vec);
    end
  endtask

  task automatic do_ack(); ack = 1; cyc(); ack = 0; endtask
  task automatic do_reti(); reti = 1; cyc(); reti = 0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0; cyc();
    // R1: reset state
    chk(creq == 1'b0, "R1 no call after reset", int'(creq), 0);
    rd(8'h0B, 8'h00, "R1 reg A after reset");
    rd(8'h1E, 8'h00, "R1 reg B after reset");

    // R2: layout and readback, all sources pending and enabled
    wr(8'h0B, 8'h7F); rd(8'h0B, 8'h7F, "R2 reg A readback");
    wr(8'h1E, 8'h77); rd(8'h1E, 8'h77, "R2 reg B readback");
    rd(8'h00, 8'h00, "R2 unmapped address");
    chk(creq == 1'b0, "R6 no call without strobe", int'(creq), 0);

    // R7: highest priority first
    strobe(8'h04, "R7 ext0 first");
    cyc(); chk(creq == 1'b0, "R6 single-cycle pulse", int'(creq), 0);
    strobe(-1, "R9 no call while pending");
    do_ack();
    rd(8'h0B, 8'h6E, "R8 ack clears flag and master enable");
    rd(8'h1E, 8'h77, "R8 other flags stay pending");
    strobe(-1, "R5 master enable off blocks");
    do_reti();
    rd(8'h0B, 8'h6F, "R10 reti sets master enable");
    strobe(8'h08, "R7 ext1 second");
    do_ack();
    cyc(); cyc();
    rd(8'h0B, 8'h4E, "R10 plain return leaves enable clear");

    // R11: software re-enables while comparator pending
    wr(8'h0B, 8'h4F);
    strobe(8'h0C, "R11 serviced after software enable");
    do_ack();
    rd(8'h0B, 8'h0E, "R8 comparator flag cleared");
    wr(8'h0B, 8'h0F);
    strobe(8'h10, "R7 timer0 vector");
    do_ack(); do_reti();

    // R5: full stack blocks, then service resumes
    sfull = 1;
    strobe(-1, "R5 stack full blocks");
    sfull = 0;
    wr(8'h1E, 8'h64);
    strobe(8'h18, "R5 disabled timer1 skipped, converter served");
    do_ack(); do_reti();
    wr(8'h1E, 8'h22);
    strobe(8'h14, "R7 timer1 vector");
    do_ack(); do_reti();
    rd(8'h1E, 8'h02, "R8 timer1 flag cleared");

    // R3 / R6: event between strobes, serviced at next strobe
    evt = 6'b000001; cyc(); evt = '0;
    rd(8'h0B, 8'h1F, "R3 event sets flag");
    chk(creq == 1'b0, "R6 event alone gives no call", int'(creq), 0);
    strobe(8'h04, "R6 serviced at next strobe");
    do_ack(); do_reti();

    // R3: event beats a same-cycle software clear
    evt = 6'b000010; we = 1; addr = 8'h0B; wdata = 8'h0F; cyc();
    evt = '0; we = 0; wdata = '0;
    rd(8'h0B, 8'h2F, "R3 event wins over software clear");

    // R4: software cancel and software trigger
    wr(8'h0B, 8'h0F);
    strobe(-1, "R4 cancelled request gives no call");
    wr(8'h1E, 8'h11);
    strobe(8'h10, "R4 software-raised request");
    do_ack(); do_reti();
    cyc();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule